// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, once per received frame, whether the frame is wanted and whether it goes to the receive buffer. The destination address arrives one byte per cycle, first received byte first. While the bytes arrive, the filter compares them with the programmed station address, notes whether the destination is all-ones or has its group bit set, and runs a CRC over them to form an index into a 64-bit multicast hash table. An end-of-frame strobe then supplies the frame length and the error flags from the receive path. Those flags are the CRC error, the alignment error, the FIFO overrun and "no buffer space".

One cycle after the end-of-frame strobe, the filter raises a one-cycle result strobe. With it come an accept bit, a store bit and a status byte. Policy comes from static configuration inputs:
- promiscuous unicast
- accept multicast
- accept broadcast
- accept runt frames
- save errored frames
- monitor mode, which checks the address but never buffers the frame

Top module: `rx_addr_filter`

## Requirements
- R1: A destination whose first byte has bit 0 clear is accepted when its six bytes equal the station address. Received byte i (i = 0 first) is compared with `sta_addr[8*i+7:8*i]`.
- R2: A unicast destination that differs from the station address is rejected unless `cfg_promisc` is set. Promiscuous mode accepts any unicast destination and has no effect on group destinations.
- R3: A destination of six 0xFF bytes is broadcast. It is accepted only when `cfg_acc_bcast` is set, and status bit 5 is set for it.
- R4: Any other destination with bit 0 of its first byte set is multicast. It is accepted only when `cfg_acc_mcast` is set and the hash table bit `hash_tbl[idx]` is 1, and status bit 5 is set for it. The index `idx` is bits 31:26 of a CRC-32 computed as follows:
  - polynomial 0x04C11DB7, seed all ones, no final inversion;
  - the six bytes are fed first byte first, each byte LSB first;
  - index bits 5:3 pick the table byte and bits 2:0 pick the bit within it.
- R5: A frame with `eof_len` below 64 is a runt. It is rejected unless `cfg_acc_runt` is set, and status bit 7 flags it.
- R6: A frame with a CRC, alignment or overrun error is rejected unless `cfg_save_err` is set. Status bits 1, 2 and 3 report these errors in that order. Status bit 0 (intact) is set only for a frame with no error that is not a runt.
- R7: In monitor mode the accept decision is unchanged, `res_store` is 0, and status bit 6 is set.
- R8: An accepted frame outside monitor mode that arrives with `eof_no_space` set is not stored, and status bit 4 (missed) is set. A rejected frame never sets bit 4.
- R9: `res_valid` is high for exactly the one cycle after each `eof_valid` cycle. `res_store` is 1 only when `res_accept` is 1.
- R10: A frame that ends before six destination bytes arrived is rejected. Bytes presented after the sixth, up to the end-of-frame strobe, have no effect on the decision.
- R11: After reset, `res_valid`, `res_accept`, `res_store` and `res_status` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sta_addr | input | 48 | Station address, byte i in bits 8i+7:8i |
| hash_tbl | input | 64 | Multicast hash table |
| cfg_promisc | input | 1 | Accept any unicast destination |
| cfg_acc_mcast | input | 1 | Allow hashed multicast |
| cfg_acc_bcast | input | 1 | Allow broadcast |
| cfg_acc_runt | input | 1 | Allow frames shorter than 64 bytes |
| cfg_save_err | input | 1 | Allow frames with errors |
| cfg_monitor | input | 1 | Check addresses but never store |
| da_valid | input | 1 | Destination byte strobe |
| da_byte | input | 8 | Destination byte |
| eof_valid | input | 1 | End-of-frame strobe |
| eof_len | input | 11 | Frame length in bytes |
| eof_crc_err | input | 1 | Frame CRC error |
| eof_align_err | input | 1 | Frame alignment error |
| eof_overrun | input | 1 | Receive FIFO overrun |
| eof_no_space | input | 1 | No buffer space for this frame |
| res_valid | output | 1 | Decision strobe |
| res_accept | output | 1 | Frame passes the filter |
| res_store | output | 1 | Frame is to be buffered |
| res_status | output | 8 | Receive status byte |

## Verification
The bench programs the hash table from its own reflected-CRC model. It then sends multicast frames whose bit is set, frames whose bit is cleared, and frames that are hashed but arrive with multicast disabled. A wrong bit order, a wrong seed or a wrong index slice would therefore accept or drop the wrong frame.

Several boundaries are driven directly:
- lengths of 63 and 64, which catch an off-by-one runt limit;
- a single differing last address byte, which exposes a comparator that stops early;
- a four-byte frame and a matched frame followed by garbage bytes, which catch a counter that wraps or keeps comparing.

Promiscuous mode is applied to a multicast miss, monitor mode to a good frame, and "no space" to both accepted and rejected frames. A design that lets promiscuous mode open group traffic, that stores in monitor mode, or that reports a missed frame for a frame it rejected is caught by these cases.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  // Status byte layout, bit 7 down to bit 0.
  typedef struct packed {
    logic runt;
    logic monitor;
    logic group;
    logic missed;
    logic overrun;
    logic align;
    logic crc;
    logic intact;
  } rx_status_t;

  // One byte through the CRC, least significant bit first.
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxf_addr_cmp.sv
module rxf_addr_cmp #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    da_valid,
  input  logic [7:0]              da_byte,
  input  logic                    clr,
  input  logic [8*ADDR_BYTES-1:0] sta_addr,
  output logic                    take,
  output logic                    addr_full,
  output logic                    ucast_hit,
  output logic                    is_bcast,
  output logic                    is_mcast
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             eq_q, eq_d;
  logic             ones_q, ones_d;
  logic             grp_q, grp_d;
  logic [7:0]       cur_sta;
  logic             en;

  assign take = da_valid && !clr && (cnt_q != CNT_FULL);
  assign en   = take || clr;

  always_comb begin
    cur_sta = 8'h00;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (cnt_q == CNT_W'(i)) cur_sta = sta_addr[8*i +: 8];
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    eq_d   = eq_q;
    ones_d = ones_q;
    grp_d  = grp_q;
    if (clr) begin
      cnt_d  = '0;
      eq_d   = 1'b1;
      ones_d = 1'b1;
      grp_d  = 1'b0;
    end else if (take) begin
      cnt_d  = cnt_q + 1'b1;
      eq_d   = eq_q && (da_byte == cur_sta);
      ones_d = ones_q && (da_byte == 8'hFF);
      if (cnt_q == '0) grp_d = da_byte[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      eq_q   <= 1'b1;
      ones_q <= 1'b1;
      grp_q  <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      eq_q   <= eq_d;
      ones_q <= ones_d;
      grp_q  <= grp_d;
    end
  end

  assign addr_full = (cnt_q == CNT_FULL);
  assign is_bcast  = addr_full && ones_q;
  assign is_mcast  = addr_full && grp_q && !ones_q;
  assign ucast_hit = addr_full && !grp_q && eq_q;

  // R10
  extra_byte_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_full && da_valid && !clr |=> $stable(eq_q) && $stable(cnt_q) && $stable(ones_q));

endmodule

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash #(
  parameter int HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic [7:0]           byte_in,
  input  logic                 clr,
  output logic [HASH_BITS-1:0] hash_idx
);
  import rxf_pkg::*;

  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)       crc_d = CRC_SEED;
    else if (take) crc_d = crc_step_byte(crc_q, byte_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            crc_q <= CRC_SEED;
    else if (take || clr)  crc_q <= crc_d;
  end

  assign hash_idx = crc_q[31 -: HASH_BITS];

  // R4
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take && !clr |=> $stable(crc_q));

endmodule

// File: rtl/rxf_policy.sv
module rxf_policy #(
  parameter int LEN_W     = 11,
  parameter int MIN_LEN   = 64,
  parameter int HASH_BITS = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    eof_valid,
  input  logic [LEN_W-1:0]        eof_len,
  input  logic                    eof_crc_err,
  input  logic                    eof_align_err,
  input  logic                    eof_overrun,
  input  logic                    eof_no_space,
  input  logic                    cfg_promisc,
  input  logic                    cfg_acc_mcast,
  input  logic                    cfg_acc_bcast,
  input  logic                    cfg_acc_runt,
  input  logic                    cfg_save_err,
  input  logic                    cfg_monitor,
  input  logic                    addr_full,
  input  logic                    ucast_hit,
  input  logic                    is_bcast,
  input  logic                    is_mcast,
  input  logic [HASH_BITS-1:0]    hash_idx,
  input  logic [2**HASH_BITS-1:0] hash_tbl,
  output logic                    res_valid,
  output logic                    res_accept,
  output logic                    res_store,
  output logic [7:0]              res_status
);
  import rxf_pkg::*;

  logic       hash_hit, ucast_frame, addr_ok, runt, any_err;
  logic       acc_d, store_d;
  rx_status_t st_d, st_q;
  logic       valid_q, acc_q, store_q;

  always_comb begin
    hash_hit    = hash_tbl[hash_idx];
    ucast_frame = addr_full && !is_bcast && !is_mcast;
    addr_ok     = ucast_hit
               || (ucast_frame && cfg_promisc)
               || (is_bcast && cfg_acc_bcast)
               || (is_mcast && cfg_acc_mcast && hash_hit);
    runt        = eof_len < LEN_W'(MIN_LEN);
    any_err     = eof_crc_err || eof_align_err || eof_overrun;
    acc_d       = addr_ok && (!runt || cfg_acc_runt) && (!any_err || cfg_save_err);
    store_d     = acc_d && !cfg_monitor && !eof_no_space;
    st_d.intact  = !any_err && !runt;
    st_d.crc     = eof_crc_err;
    st_d.align   = eof_align_err;
    st_d.overrun = eof_overrun;
    st_d.missed  = acc_d && !cfg_monitor && eof_no_space;
    st_d.group   = is_bcast || is_mcast;
    st_d.monitor = cfg_monitor;
    st_d.runt    = runt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= eof_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 1'b0;
      store_q <= 1'b0;
      st_q    <= '0;
    end else if (eof_valid) begin
      acc_q   <= acc_d;
      store_q <= store_d;
      st_q    <= st_d;
    end
  end

  assign res_valid  = valid_q;
  assign res_accept = acc_q;
  assign res_store  = store_q;
  assign res_status = st_q;

  // R9
  store_implies_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_store |-> res_accept);
  // R9
  res_follows_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(eof_valid));
  // R7
  monitor_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_status[6] |-> !res_store);
  // R8
  missed_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_status[4] |-> !res_store && res_accept);
  // R5
  runt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_accept && res_status[7] |-> $past(cfg_acc_runt));
  // R6
  err_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_accept && (res_status[3:1] != 3'b000) |-> $past(cfg_save_err));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int LEN_W      = 11,
  parameter int MIN_LEN    = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [8*ADDR_BYTES-1:0] sta_addr,
  input  logic [2**HASH_BITS-1:0] hash_tbl,
  input  logic                    cfg_promisc,
  input  logic                    cfg_acc_mcast,
  input  logic                    cfg_acc_bcast,
  input  logic                    cfg_acc_runt,
  input  logic                    cfg_save_err,
  input  logic                    cfg_monitor,
  input  logic                    da_valid,
  input  logic [7:0]              da_byte,
  input  logic                    eof_valid,
  input  logic [LEN_W-1:0]        eof_len,
  input  logic                    eof_crc_err,
  input  logic                    eof_align_err,
  input  logic                    eof_overrun,
  input  logic                    eof_no_space,
  output logic                    res_valid,
  output logic                    res_accept,
  output logic                    res_store,
  output logic [7:0]              res_status
);
  logic                 take, addr_full, ucast_hit, is_bcast, is_mcast;
  logic [HASH_BITS-1:0] hash_idx;

  rxf_addr_cmp #(.ADDR_BYTES(ADDR_BYTES)) u_cmp (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_byte(da_byte),
    .clr(eof_valid), .sta_addr(sta_addr), .take(take), .addr_full(addr_full),
    .ucast_hit(ucast_hit), .is_bcast(is_bcast), .is_mcast(is_mcast)
  );

  rxf_crc_hash #(.HASH_BITS(HASH_BITS)) u_hash (
    .clk(clk), .rst_n(rst_n), .take(take), .byte_in(da_byte),
    .clr(eof_valid), .hash_idx(hash_idx)
  );

  rxf_policy #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .HASH_BITS(HASH_BITS)) u_pol (
    .clk(clk), .rst_n(rst_n), .eof_valid(eof_valid), .eof_len(eof_len),
    .eof_crc_err(eof_crc_err), .eof_align_err(eof_align_err),
    .eof_overrun(eof_overrun), .eof_no_space(eof_no_space),
    .cfg_promisc(cfg_promisc), .cfg_acc_mcast(cfg_acc_mcast),
    .cfg_acc_bcast(cfg_acc_bcast), .cfg_acc_runt(cfg_acc_runt),
    .cfg_save_err(cfg_save_err), .cfg_monitor(cfg_monitor),
    .addr_full(addr_full), .ucast_hit(ucast_hit), .is_bcast(is_bcast),
    .is_mcast(is_mcast), .hash_idx(hash_idx), .hash_tbl(hash_tbl),
    .res_valid(res_valid), .res_accept(res_accept), .res_store(res_store),
    .res_status(res_status)
  );

endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] sta_addr;
  logic [63:0] hash_tbl;
  logic        cfg_promisc, cfg_acc_mcast, cfg_acc_bcast, cfg_acc_runt, cfg_save_err, cfg_monitor;
  logic        da_valid;
  logic [7:0]  da_byte;
  logic        eof_valid;
  logic [10:0] eof_len;
  logic        eof_crc_err, eof_align_err, eof_overrun, eof_no_space;
  logic        res_valid, res_accept, res_store;
  logic [7:0]  res_status;

  rx_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .sta_addr(sta_addr), .hash_tbl(hash_tbl),
    .cfg_promisc(cfg_promisc), .cfg_acc_mcast(cfg_acc_mcast),
    .cfg_acc_bcast(cfg_acc_bcast), .cfg_acc_runt(cfg_acc_runt),
    .cfg_save_err(cfg_save_err), .cfg_monitor(cfg_monitor),
    .da_valid(da_valid), .da_byte(da_byte), .eof_valid(eof_valid),
    .eof_len(eof_len), .eof_crc_err(eof_crc_err), .eof_align_err(eof_align_err),
    .eof_overrun(eof_overrun), .eof_no_space(eof_no_space),
    .res_valid(res_valid), .res_accept(res_accept), .res_store(res_store),
    .res_status(res_status)
  );

  always #2.5ns clk = ~clk;

  typedef struct {
    logic       acc;
    logic       sto;
    logic [7:0] st;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reflected CRC form; index bit 5 is the reflected register's bit 0.
  function automatic logic [5:0] hash_of(input logic [47:0] da);
    logic [31:0] r;
    logic        fb;
    r = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      for (int b = 0; b < 8; b++) begin
        fb = r[0] ^ da[8*i+b];
        r  = r >> 1;
        if (fb) r = r ^ 32'hEDB8_8320;
      end
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  function automatic exp_t model(input logic [47:0] da, input int nb, input int len,
                                 input bit ce, input bit ae, input bit oe, input bit ns,
                                 input string tag);
    exp_t e;
    bit full, bc, mc, uc, ok, runt, err;
    full = (nb >= 6);
    bc   = full && (da == 48'hFFFF_FFFF_FFFF);
    mc   = full && da[0] && !bc;
    uc   = full && !da[0];
    ok   = (uc && (da == sta_addr || cfg_promisc)) || (bc && cfg_acc_bcast)
        || (mc && cfg_acc_mcast && hash_tbl[hash_of(da)]);
    runt = (len < 64);
    err  = ce || ae || oe;
    e.acc = ok && (!runt || cfg_acc_runt) && (!err || cfg_save_err);
    e.sto = e.acc && !cfg_monitor && !ns;
    e.st  = {runt, cfg_monitor, bc || mc, e.acc && !cfg_monitor && ns, oe, ae, ce, !err && !runt};
    e.tag = tag;
    return e;
  endfunction

  task automatic send_frame(input logic [47:0] da, input int nb, input int extra, input int len,
                            input bit ce, input bit ae, input bit oe, input bit ns, input string tag);
    exp_q.push_back(model(da, nb, len, ce, ae, oe, ns, tag));
    for (int i = 0; i < nb + extra; i++) begin
      @(negedge clk);
      da_valid = 1'b1;
      da_byte  = (i < nb) ? da[8*i +: 8] : 8'h5A;
    end
    @(negedge clk);
    da_valid = 1'b0;
    @(negedge clk);
    eof_valid = 1'b1; eof_len = 11'(len);
    eof_crc_err = ce; eof_align_err = ae; eof_overrun = oe; eof_no_space = ns;
    @(negedge clk);
    eof_valid = 1'b0; eof_crc_err = 1'b0; eof_align_err = 1'b0; eof_overrun = 1'b0; eof_no_space = 1'b0;
    check("R9", {tag, " strobe one cycle after eof"}, res_valid, 1);
    @(negedge clk);
    check("R9", {tag, " strobe lasts one cycle"}, res_valid, 0);
  endtask

  // Monitor: pops the scoreboard on each result strobe.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && res_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check("R9", "unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "accept", res_accept, e.acc);
        check(e.tag, "store", res_store, e.sto);
        check(e.tag, "status", res_status, e.st);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  localparam logic [47:0] STA   = 48'h5544_3322_1102;
  localparam logic [47:0] OTHER = 48'h9944_3322_1102;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC1   = 48'h0100_005E_0001;
  localparam logic [47:0] MC2   = 48'h3412_0000_5E01;

  initial begin
    rst_n = 1'b0;
    sta_addr = STA; hash_tbl = '0;
    cfg_promisc = 0; cfg_acc_mcast = 0; cfg_acc_bcast = 0;
    cfg_acc_runt = 0; cfg_save_err = 0; cfg_monitor = 0;
    da_valid = 0; da_byte = 0; eof_valid = 0; eof_len = 0;
    eof_crc_err = 0; eof_align_err = 0; eof_overrun = 0; eof_no_space = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "res_valid", res_valid, 0);
    check("R11", "res_accept", res_accept, 0);
    check("R11", "res_store", res_store, 0);
    check("R11", "res_status", res_status, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send_frame(STA,   6, 0, 100, 0, 0, 0, 0, "R1");
    send_frame(OTHER, 6, 0, 100, 0, 0, 0, 0, "R2");
    cfg_promisc = 1;
    send_frame(OTHER, 6, 0, 100, 0, 0, 0, 0, "R2");
    send_frame(MC1,   6, 0, 100, 0, 0, 0, 0, "R2");
    cfg_promisc = 0;

    send_frame(BCAST, 6, 0, 100, 0, 0, 0, 0, "R3");
    cfg_acc_bcast = 1;
    send_frame(BCAST, 6, 0, 100, 0, 0, 0, 0, "R3");

    cfg_acc_mcast = 1;
    send_frame(MC1, 6, 0, 100, 0, 0, 0, 0, "R4");
    hash_tbl = 64'd1 << hash_of(MC1);
    send_frame(MC1, 6, 0, 100, 0, 0, 0, 0, "R4");
    hash_tbl = 64'd1 << hash_of(MC2);
    send_frame(MC2, 6, 0, 100, 0, 0, 0, 0, "R4");
    if (hash_of(MC1) != hash_of(MC2))
      send_frame(MC1, 6, 0, 100, 0, 0, 0, 0, "R4");
    cfg_acc_mcast = 0;
    send_frame(MC2, 6, 0, 100, 0, 0, 0, 0, "R4");

    send_frame(STA, 6, 0, 63, 0, 0, 0, 0, "R5");
    send_frame(STA, 6, 0, 64, 0, 0, 0, 0, "R5");
    cfg_acc_runt = 1;
    send_frame(STA, 6, 0, 40, 0, 0, 0, 0, "R5");
    cfg_acc_runt = 0;

    send_frame(STA, 6, 0, 100, 1, 0, 0, 0, "R6");
    send_frame(STA, 6, 0, 100, 0, 1, 0, 0, "R6");
    send_frame(STA, 6, 0, 100, 0, 0, 1, 0, "R6");
    cfg_save_err = 1;
    send_frame(STA, 6, 0, 100, 1, 1, 0, 0, "R6");
    cfg_save_err = 0;

    cfg_monitor = 1;
    send_frame(STA,   6, 0, 100, 0, 0, 0, 0, "R7");
    send_frame(OTHER, 6, 0, 100, 0, 0, 0, 0, "R7");
    cfg_monitor = 0;

    send_frame(STA,   6, 0, 100, 0, 0, 0, 1, "R8");
    send_frame(OTHER, 6, 0, 100, 0, 0, 0, 1, "R8");

    send_frame(STA, 4, 0, 100, 0, 0, 0, 0, "R10");
    send_frame(STA, 6, 3, 100, 0, 0, 0, 0, "R10");
    send_frame(STA, 6, 0, 100, 0, 0, 0, 0, "R1");

    repeat (3) @(negedge clk);
    check("R9", "results outstanding", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule